// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple register bus made of an address, a write strobe, write data and combinational read data. A programmable 8-bit prescaler divides the input clock by P+1. A fixed divider of 16, 32, 64 or 128 then divides it again, and each resulting tick decrements a 16-bit counter. Software keeps the system alive by writing the counter directly. When the counter runs out it is refilled from a separate reload register. Depending on two control bits, the block then sets a sticky interrupt, fires a system-reset pulse of fixed length, or does both.

The bus has no back-pressure and no valid/ready handshake: a write takes effect at the clock edge where the write strobe is high, and read data follows the address in the same cycle. The interrupt and reset pins are plain level outputs. The interrupt is cleared by writing to a dedicated clear register.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register reads 0x8021 (timer on, reset output on, prescaler 0x80, divide by 16), the reload and count registers both read 0x8000, and `irq_o` and `sys_rst_o` are low.
- R2: The registers sit at these offsets: control at 0x0, reload at 0x4, count at 0x8, interrupt clear at 0x C. Control bit 0 enables the reset output, bit 2 enables the interrupt, bit 5 runs the timer, bits [4:3] select the divider, and bits [15:8] hold the prescaler P. All other control bits, and any read of offset 0xC, return 0.
- R3: While bit 5 is set, the counter decrements once every (P+1)·(16<<sel) clocks. The first decrement lands exactly that many clocks after the edge that set bit 5.
- R4: A write to offset 0x8 sets the count to the written value at that edge. Such a write wins over a tick in the same cycle, and that tick neither decrements the counter nor expires it.
- R5: A tick that finds the count at 1 or 0 is an expiry: the count takes the value of the reload register instead of decrementing.
- R6: An expiry with bit 2 set raises `irq_o`, which stays high until a write to 0xC with data bit 0 equal to 1. A clear write with bit 0 equal to 0 has no effect. An expiry and a clear in the same cycle leave `irq_o` high.
- R7: An expiry with bit 0 set drives `sys_rst_o` high for exactly 128 clocks. Without an expiry, `sys_rst_o` never rises.
- R8: While bit 5 is clear, the count holds its value, and both the count and the reload register can still be written. Setting bit 5 again restarts the tick phase from zero.
- R9: An expiry with bits 0 and 2 both clear leaves `irq_o` and `sys_rst_o` low, and the counter still reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Byte offset of the register accessed |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Sticky watchdog interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench forces two pairs of collisions at exact cycles. In the first, a keep-alive write lands on the same edge as a tick: the count must read the written value, not that value minus one. In the second, an interrupt-clear write lands on the same edge as an expiry: `irq_o` must stay high, because the new event wins. Both collisions are placed by counting clocks from the edge that enables the timer. A behavioural model of the period and the counter judges them, and is compared with the read data, `irq_o` and `sys_rst_o` on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned BUS_AW = 4;
  localparam int unsigned BUS_DW = 16;

  localparam logic [BUS_AW-1:0] OFS_CTRL   = 4'h0;
  localparam logic [BUS_AW-1:0] OFS_RELOAD = 4'h4;
  localparam logic [BUS_AW-1:0] OFS_COUNT  = 4'h8;
  localparam logic [BUS_AW-1:0] OFS_CLEAR  = 4'hC;

  localparam int unsigned BIT_RST_EN = 0;
  localparam int unsigned BIT_IRQ_EN = 2;
  localparam int unsigned SEL_LSB    = 3;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned BIT_RUN    = 5;
  localparam int unsigned PRE_LSB    = 8;
  localparam int unsigned PRE_W      = 8;

  localparam logic [BUS_DW-1:0] CTRL_MASK  = 16'hFF3D;
  localparam logic [BUS_DW-1:0] CTRL_RESET = 16'h8021;
  localparam logic [BUS_DW-1:0] DATA_RESET = 16'h8000;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned DIV_BASE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DCNT_W = DIV_BASE + (1 << SEL_W) - 1;

  logic [PRE_W-1:0]  pcnt_q;
  logic [DCNT_W-1:0] dcnt_q;
  logic [DCNT_W-1:0] dlim;
  logic              pre_wrap;
  logic              div_wrap;

  // the last value of the divider stage for the selected ratio
  assign dlim     = DCNT_W'((1 << (DIV_BASE + int'(sel_i))) - 1);
  assign pre_wrap = (pcnt_q >= pre_i);
  assign div_wrap = (dcnt_q >= dlim);
  assign tick_o   = en_i & pre_wrap & div_wrap;

  // both stages are held at zero while stopped, so a restart begins at phase zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else if (!en_i) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else if (pre_wrap) begin
      pcnt_q <= '0;
      dcnt_q <= div_wrap ? '0 : dcnt_q + 1'b1;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  p_idle_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pcnt_q == '0) && (dcnt_q == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned        CNT_W     = 16,
  parameter logic [CNT_W-1:0]   RST_COUNT = 16'h8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;

  // a keep-alive load in the same cycle as a tick suppresses that tick
  assign expire_o = tick_i & ~load_i & (count_q <= CNT_W'(1));
  assign count_o  = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= RST_COUNT;
    else if (load_i)   count_q <= load_val_i;
    else if (expire_o) count_q <= reload_i;
    else if (tick_i)   count_q <= count_q - 1'b1;
  end

  p_load_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i));
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> count_o == $past(reload_i));
  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/wdog_events.sv
module wdog_events #(
  parameter int unsigned PULSE_LEN = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic irq_en_i,
  input  logic rst_en_i,
  input  logic clr_i,
  output logic irq_o,
  output logic sys_rst_o
);
  localparam int unsigned RC_W = $clog2(PULSE_LEN + 1);

  logic            irq_q;
  logic [RC_W-1:0] left_q;

  // a fresh event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    irq_q <= 1'b0;
    else if (expire_i && irq_en_i)  irq_q <= 1'b1;
    else if (clr_i)                 irq_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    left_q <= '0;
    else if (expire_i && rst_en_i)  left_q <= RC_W'(PULSE_LEN);
    else if (left_q != '0)          left_q <= left_q - 1'b1;
  end

  assign irq_o     = irq_q;
  assign sys_rst_o = (left_q != '0);

  p_irq_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(expire_i && irq_en_i));
  p_irq_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  p_rst_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(expire_i && rst_en_i));
  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !irq_en_i && !irq_o) |=> !irq_o);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 128,
  parameter int unsigned DIV_BASE  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic [BUS_DW-1:0] ctrl_q;
  logic [BUS_DW-1:0] reload_q;
  logic [BUS_DW-1:0] count;
  logic              wr_ctrl, wr_reload, wr_count, wr_clear;
  logic              tick, expire;

  assign wr_ctrl   = bus_we_i && (bus_addr_i == OFS_CTRL);
  assign wr_reload = bus_we_i && (bus_addr_i == OFS_RELOAD);
  assign wr_count  = bus_we_i && (bus_addr_i == OFS_COUNT);
  assign wr_clear  = bus_we_i && (bus_addr_i == OFS_CLEAR) && bus_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RESET;
      reload_q <= DATA_RESET;
    end else begin
      if (wr_ctrl)   ctrl_q   <= bus_wdata_i & CTRL_MASK;
      if (wr_reload) reload_q <= bus_wdata_i;
    end
  end

  wdog_tick_gen #(.PRE_W(PRE_W), .SEL_W(SEL_W), .DIV_BASE(DIV_BASE)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q[BIT_RUN]),
    .pre_i  (ctrl_q[PRE_LSB +: PRE_W]),
    .sel_i  (ctrl_q[SEL_LSB +: SEL_W]),
    .tick_o (tick)
  );

  wdog_counter #(.CNT_W(BUS_DW), .RST_COUNT(DATA_RESET)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (wr_count),
    .load_val_i (bus_wdata_i),
    .reload_i   (reload_q),
    .count_o    (count),
    .expire_o   (expire)
  );

  wdog_events #(.PULSE_LEN(PULSE_LEN)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .irq_en_i  (ctrl_q[BIT_IRQ_EN]),
    .rst_en_i  (ctrl_q[BIT_RST_EN]),
    .clr_i     (wr_clear),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      OFS_CTRL:   bus_rdata_o = ctrl_q;
      OFS_RELOAD: bus_rdata_o = reload_q;
      OFS_COUNT:  bus_rdata_o = count;
      default:    bus_rdata_o = '0;
    endcase
  end

  p_tick_needs_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> ctrl_q[BIT_RUN]);
  p_ctrl_reserved_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~CTRL_MASK) == '0);
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic        we = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        irq, srst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst)
  );

  // behavioural reference model
  logic [15:0] m_ctrl = 16'h8021, m_data = 16'h8000, m_cnt = 16'h8000;
  int          m_phase = 0;
  bit          m_irq = 0;
  int          m_left = 0;
  bit          m_valid = 0;
  int          per;
  bit          m_tick, m_load, m_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 16'h8021; m_data = 16'h8000; m_cnt = 16'h8000;
      m_phase = 0; m_irq = 0; m_left = 0; m_valid = 1;
    end else begin
      per    = (int'(m_ctrl[15:8]) + 1) * (16 << m_ctrl[4:3]);
      m_tick = m_ctrl[5] && (m_phase == per - 1);
      m_load = we && addr == 4'h8;
      m_exp  = m_tick && !m_load && (m_cnt <= 1);
      m_phase = !m_ctrl[5] ? 0 : (m_tick ? 0 : m_phase + 1);
      if (m_exp && m_ctrl[2]) m_irq = 1;
      else if (we && addr == 4'hC && wdata[0]) m_irq = 0;
      if (m_exp && m_ctrl[0]) m_left = 128;
      else if (m_left > 0) m_left = m_left - 1;
      if (m_load) m_cnt = wdata;
      else if (m_exp) m_cnt = m_data;
      else if (m_tick) m_cnt = m_cnt - 1;
      if (we && addr == 4'h0) m_ctrl = wdata & 16'hFF3D;
      if (we && addr == 4'h4) m_data = wdata;
    end
  end

  function automatic logic [15:0] m_rd(input logic [3:0] a);
    case (a)
      4'h0: return m_ctrl;
      4'h4: return m_data;
      4'h8: return m_cnt;
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && m_valid && !done) begin
      check("R3 count/readback vs model", {16'h0, rdata}, {16'h0, m_rd(addr)});
      check("R6 irq vs model", {31'h0, irq}, {31'h0, m_irq});
      check("R7 reset vs model", {31'h0, srst}, {31'h0, (m_left > 0)});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [15:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, {16'h0, rdata}, {16'h0, exp});
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd("R1 ctrl reset", 4'h0, 16'h8021);
    rd("R1 reload reset", 4'h4, 16'h8000);
    check("R1 irq reset", {31'h0, irq}, 32'h0);
    check("R1 sys_rst reset", {31'h0, srst}, 32'h0);
    wr(4'h0, 16'h0000);
    rd("R1 count reset", 4'h8, 16'h8000);
    // R2 field mask and offsets
    wr(4'h0, 16'hFFDF);
    rd("R2 ctrl reserved bits", 4'h0, 16'hFF1D);
    wr(4'h0, 16'h0000);
    wr(4'h4, 16'h1234);
    rd("R2 reload offset", 4'h4, 16'h1234);
    wr(4'hC, 16'h0000);
    rd("R2 clear offset reads 0", 4'hC, 16'h0000);
    // R3 exact first tick
    wr(4'h4, 16'h0005); wr(4'h8, 16'd10); wr(4'h0, 16'h0120);
    repeat (31) @(posedge clk);
    rd("R3 no tick before period", 4'h8, 16'd10);
    @(posedge clk);
    rd("R3 tick at period", 4'h8, 16'd9);
    // R4 keep-alive on the tick edge
    wr(4'h0, 16'h0000); wr(4'h8, 16'd10); wr(4'h0, 16'h0120);
    repeat (31) @(posedge clk);
    wr(4'h8, 16'h0055);
    rd("R4 load wins over tick", 4'h8, 16'h0055);
    // R5 R6 R7 expiry with both outputs enabled
    wr(4'h0, 16'h0000); wr(4'hC, 16'h0001);
    wr(4'h4, 16'h0100); wr(4'h8, 16'h0002); wr(4'h0, 16'h0025);
    repeat (31) @(posedge clk);
    check("R6 irq low before expiry", {31'h0, irq}, 32'h0);
    @(posedge clk);
    rd("R5 reload on expiry", 4'h8, 16'h0100);
    check("R6 irq set on expiry", {31'h0, irq}, 32'h1);
    n = 0;
    while (srst && n < 1000) begin n++; @(negedge clk); end
    check("R7 pulse length", n, 128);
    wr(4'hC, 16'h0000);
    check("R6 clear with bit0=0 ignored", {31'h0, irq}, 32'h1);
    wr(4'hC, 16'h0001);
    check("R6 clear", {31'h0, irq}, 32'h0);
    // R6 expiry and clear in the same cycle
    wr(4'h0, 16'h0000); wr(4'h8, 16'h0001); wr(4'h0, 16'h0124);
    repeat (31) @(posedge clk);
    wr(4'hC, 16'h0001);
    check("R6 expiry beats clear", {31'h0, irq}, 32'h1);
    check("R7 no pulse when reset disabled", {31'h0, srst}, 32'h0);
    wr(4'hC, 16'h0001);
    // R8 freeze and restart
    wr(4'h0, 16'h0000); wr(4'h8, 16'h0040); wr(4'h0, 16'h0020);
    repeat (40) @(posedge clk);
    wr(4'h0, 16'h0000);
    repeat (100) @(posedge clk);
    rd("R8 count frozen", 4'h8, 16'h003E);
    wr(4'h4, 16'h0009); wr(4'h8, 16'h0020);
    rd("R8 reload written while off", 4'h4, 16'h0009);
    rd("R8 count written while off", 4'h8, 16'h0020);
    wr(4'h0, 16'h0020);
    repeat (15) @(posedge clk);
    rd("R8 phase restarted", 4'h8, 16'h0020);
    @(posedge clk);
    rd("R8 first tick after restart", 4'h8, 16'h001F);
    // R9 silent expiry
    wr(4'h0, 16'h0000); wr(4'h8, 16'h0001); wr(4'h4, 16'h0077); wr(4'h0, 16'h0020);
    repeat (20) @(posedge clk);
    rd("R9 counter reloads", 4'h8, 16'h0077);
    check("R9 irq stays low", {31'h0, irq}, 32'h0);
    check("R9 sys_rst stays low", {31'h0, srst}, 32'h0);
    wr(4'h0, 16'h0000);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule